// File: doc/BRIEF.md
# Ring-Counter Instruction Sequencer

This block is the control unit of a small 4-bit processor built for minimum area. It holds a 4-bit program counter and a 4-bit instruction register, and it reads opcodes from a 16-word program store outside the block. The store answers combinationally on the address the block drives. A four-slot one-hot ring counter steps every instruction through four clocks: fetch, decode, execute and counter advance. No encoded state machine is used.

The held opcode is expanded into sixteen one-hot decode lines. Each line is ANDed with the execute slot to give one strobe per opcode. A datapath uses these strobes as register-load enables and ALU operation selects. The load-B strobe (opcode 4'b1010) is also brought out as a separate pin. Every flip-flop runs on the one clock, and sequencing is done only through enables.

Top module: `seq_ctrl_top`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `pc` and `ir` to 0 and sets `slot` to 4'b0001 (fetch). The reset is synchronous and active high.
- R2: Outside reset, `slot` always has exactly one bit set. It walks fetch 4'b0001 → decode 4'b0010 → execute 4'b0100 → advance 4'b1000 → fetch, one step per clock.
- R3: At the edge that ends the fetch slot, `ir` takes the value of `rom_data`, which is the program word at the address `rom_addr` shows during that slot.
- R4: `rom_addr` increases by one only at the edge that ends the advance slot. In every other slot it holds.
- R5: The program counter wraps from 15 to 0.
- R6: `dec_line` always has exactly one bit set, at the position given by the value of `ir`.
- R7: `exec_en[k]` is high only during the execute slot and only when `ir` equals k. In every other slot all sixteen bits are low, whatever opcode is held.
- R8: `ld_b_en` is high only during the execute slot of an instruction whose opcode is 4'b1010.
- R9: Changes on `rom_data` during the decode, execute or advance slots do not alter `ir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_data | input | 4 | Program word read at `rom_addr` |
| rom_addr | output | 4 | Program counter, used as the program-store address |
| slot | output | 4 | One-hot timing slot (bit0 fetch … bit3 advance) |
| ir | output | 4 | Instruction register |
| dec_line | output | 16 | One-hot decode of `ir` |
| exec_en | output | 16 | Decode lines gated by the execute slot |
| ld_b_en | output | 1 | Load-B strobe (opcode 4'b1010 in execute slot) |

## Verification
The slot advances one edge after each clock, so the bench checks a new slot value at every falling edge. The instruction word fetched at address k first shows on `ir` and `dec_line` one edge after the fetch slot, which is the decode slot. Its strobe appears on `exec_en` two edges after the fetch slot and is gone one edge later. `rom_addr` moves to k+1 four edges after the fetch of k. Inputs change only at falling edges, and each result is sampled at the falling edge after the rising edge that produces it. The bench also rewrites the program word during the decode slot and checks that `ir` does not follow it.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
    localparam int OP_W      = 4;
    localparam int NUM_OPS   = 1 << OP_W;
    localparam int PC_W      = 4;
    localparam int NUM_SLOTS = 4;

    localparam logic [NUM_SLOTS-1:0] SLOT_FETCH   = 4'b0001;
    localparam logic [NUM_SLOTS-1:0] SLOT_DECODE  = 4'b0010;
    localparam logic [NUM_SLOTS-1:0] SLOT_EXEC    = 4'b0100;
    localparam logic [NUM_SLOTS-1:0] SLOT_ADVANCE = 4'b1000;

    localparam int IDX_FETCH   = 0;
    localparam int IDX_EXEC    = 2;
    localparam int IDX_ADVANCE = 3;

    localparam logic [OP_W-1:0] OP_LOAD_B = 4'b1010;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [OP_W-1:0] ir;
    } fetch_state_t;

    function automatic logic single_hot(input logic [NUM_SLOTS-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/slot_ring.sv
module slot_ring
    import seq_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    output logic [NUM_SLOTS-1:0] slot
);
    logic [NUM_SLOTS-1:0] slot_q;
    logic [NUM_SLOTS-1:0] slot_d;

    always_comb begin
        if (single_hot(slot_q))
            slot_d = {slot_q[NUM_SLOTS-2:0], slot_q[NUM_SLOTS-1]};
        else
            slot_d = SLOT_FETCH;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_FETCH;
        else     slot_q <= slot_d;
    end

    assign slot = slot_q;

    p_slot_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_q) == 1);
    p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
        slot_q == SLOT_FETCH |=> slot_q == SLOT_DECODE);
    p_advance_to_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        slot_q == SLOT_ADVANCE |=> slot_q == SLOT_FETCH);
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
    import seq_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] slot,
    input  logic [OP_W-1:0]      rom_data,
    output fetch_state_t         state
);
    fetch_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (slot[IDX_FETCH])   st_q.ir <= rom_data;
            if (slot[IDX_ADVANCE]) st_q.pc <= st_q.pc + 1'b1;
        end
    end

    assign state = st_q;

    p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !slot[IDX_ADVANCE] |=> $stable(st_q.pc));
    p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
        slot[IDX_ADVANCE] |=> st_q.pc == PC_W'($past(st_q.pc) + 1));
    p_ir_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !slot[IDX_FETCH] |=> $stable(st_q.ir));
    p_ir_load_r3: assert property (@(posedge clk) disable iff (rst)
        slot[IDX_FETCH] |=> st_q.ir == $past(rom_data));
endmodule

// File: rtl/op_decoder.sv
module op_decoder
    import seq_ctrl_pkg::*;
(
    input  logic [OP_W-1:0]    opcode,
    input  logic               exec_slot,
    output logic [NUM_OPS-1:0] lines,
    output logic [NUM_OPS-1:0] strobes
);
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_line
        assign lines[k]   = (opcode == OP_W'(k));
        assign strobes[k] = lines[k] & exec_slot;
    end

    always_comb begin
        p_lines_onehot_r6: assert ($countones(lines) == 1 || $isunknown(opcode));
        p_strobe_le_one_r7: assert ($countones(strobes) <= 1 || $isunknown(opcode));
    end
endmodule

// File: rtl/seq_ctrl_top.sv
module seq_ctrl_top
    import seq_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OP_W-1:0]      rom_data,
    output logic [PC_W-1:0]      rom_addr,
    output logic [NUM_SLOTS-1:0] slot,
    output logic [OP_W-1:0]      ir,
    output logic [NUM_OPS-1:0]   dec_line,
    output logic [NUM_OPS-1:0]   exec_en,
    output logic                 ld_b_en
);
    fetch_state_t fst;

    slot_ring u_ring (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    fetch_regs u_fetch (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .rom_data (rom_data),
        .state    (fst)
    );

    op_decoder u_dec (
        .opcode    (fst.ir),
        .exec_slot (slot[IDX_EXEC]),
        .lines     (dec_line),
        .strobes   (exec_en)
    );

    assign rom_addr = fst.pc;
    assign ir       = fst.ir;
    assign ld_b_en  = exec_en[OP_LOAD_B];

    p_ldb_only_exec_r8: assert property (@(posedge clk) disable iff (rst)
        ld_b_en |-> (ir == OP_LOAD_B) && (slot == SLOT_EXEC));
    p_exec_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        slot != SLOT_EXEC |-> exec_en == '0);
endmodule

// File: tb/seq_ctrl_top_tb.sv
module seq_ctrl_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rom [16];
    logic [3:0]  rom_data;
    logic [3:0]  rom_addr;
    logic [3:0]  slot;
    logic [3:0]  ir;
    logic [15:0] dec_line;
    logic [15:0] exec_en;
    logic        ld_b_en;

    int checks   = 0;
    int failures = 0;

    localparam logic [3:0] PROG [16] = '{
        4'd10, 4'd3, 4'd0, 4'd15, 4'd7, 4'd12, 4'd1, 4'd5,
        4'd9, 4'd14, 4'd2, 4'd8, 4'd11, 4'd4, 4'd13, 4'd6
    };

    always #2.5 clk = ~clk;

    assign rom_data = rom[rom_addr];

    seq_ctrl_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .slot     (slot),
        .ir       (ir),
        .dec_line (dec_line),
        .exec_en  (exec_en),
        .ld_b_en  (ld_b_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state();
        chk("R1", "slot", 32'(slot), 32'h1);
        chk("R1", "pc",   32'(rom_addr), 32'h0);
        chk("R1", "ir",   32'(ir), 32'h0);
        chk("R7", "exec during reset", 32'(exec_en), 32'h0);
    endtask

    initial begin
        #1ms;
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rom[i] = PROG[i];
        repeat (3) @(negedge clk);
        chk_reset_state();                         // R1
        rst = 1'b0;

        // Vector walk: one full program pass, 4 slots per instruction
        for (int i = 0; i < 16; i++) begin
            logic [3:0]  op;
            logic [15:0] hot;
            op  = PROG[i];
            hot = 16'(1) << op;
            chk("R2", "fetch slot", 32'(slot), 32'h1);
            chk("R4", "pc in fetch", 32'(rom_addr), 32'(i));
            chk("R7", "exec in fetch", 32'(exec_en), 32'h0);
            @(negedge clk);
            chk("R2", "decode slot", 32'(slot), 32'h2);
            chk("R3", "ir loaded", 32'(ir), 32'(op));
            chk("R6", "decode line", 32'(dec_line), 32'(hot));
            chk("R7", "exec in decode", 32'(exec_en), 32'h0);
            chk("R4", "pc in decode", 32'(rom_addr), 32'(i));
            rom[i] = ~op;                          // R9 stimulus
            @(negedge clk);
            chk("R2", "exec slot", 32'(slot), 32'h4);
            chk("R9", "ir after rom change", 32'(ir), 32'(op));
            chk("R7", "exec strobe", 32'(exec_en), 32'(hot));
            chk("R8", "load B strobe", 32'(ld_b_en), 32'(op == 4'b1010));
            @(negedge clk);
            chk("R2", "advance slot", 32'(slot), 32'h8);
            chk("R7", "exec in advance", 32'(exec_en), 32'h0);
            chk("R8", "load B in advance", 32'(ld_b_en), 32'h0);
            chk("R9", "ir in advance", 32'(ir), 32'(op));
            chk("R4", "pc in advance", 32'(rom_addr), 32'(i));
            rom[i] = op;
            @(negedge clk);
        end

        // Wrap from 15 to 0
        chk("R5", "pc wrap", 32'(rom_addr), 32'h0);
        chk("R2", "fetch after wrap", 32'(slot), 32'h1);
        chk("R6", "decode line held", 32'(dec_line), 32'(16'(1) << PROG[15]));

        // Reset in the middle of an execute slot
        @(negedge clk);
        @(negedge clk);
        chk("R8", "load B before mid reset", 32'(ld_b_en), 32'h1);
        rst = 1'b1;
        @(negedge clk);
        chk_reset_state();                         // R1 mid-instruction
        chk("R8", "load B in reset", 32'(ld_b_en), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R3", "refetch after reset", 32'(ir), 32'(PROG[0]));
        @(negedge clk);
        chk("R8", "load B after reset", 32'(ld_b_en), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule